// File: doc/BRIEF.md
# Audio Sample FIFO with Sticky Status

This block is a single-clock sample buffer placed between a register bus and a serial audio core. It stores 32-bit sub-frame words. The transfer direction is set in a control register. In transmit mode the bus fills the buffer through a data window and the serial core drains it. In receive mode the serial core fills the buffer and the bus drains it through the same window. A direct-ownership bit shuts the bus out of the data window so that only the serial side touches the storage.

Software sees four level conditions: empty, almost empty, full and almost full. The two "almost" limits are programmable. Two error events are also reported: a transmit underrun and a receive overrun. Each condition is latched in a sticky flag register, and software clears a flag by writing 0 to its bit. Every flag has an interrupt mask bit at the same position, and a global enable gates the single interrupt line. A live status word shows the fill level and the current conditions. A self-restoring soft reset empties the buffer and leaves the thresholds as they were.

Top module: `smp_fifo_top`

## Requirements
- R1: After reset the level is 0, the control word reads 0x0000_0001, the threshold word reads 0x000E_0002 (almost-empty 2, almost-full DEPTH-2 with DEPTH 16), irq is low, and a few cycles later the flag word (address 1) reads 0x0000_0300.
- R2: In transmit mode (control bit 1 = 1, bit 2 = 0), bus writes to address 4 push words, and core_pop returns them on core_rdata in the order written.
- R3: In receive mode (control bit 1 = 0, bit 2 = 0), core_push stores words, and a bus read of address 4 returns the oldest word and removes it.
- R4: The status word (address 3) holds the level in bits [4:0], and the live empty, almost-empty, full and almost-full conditions in bits 8, 9, 10 and 11.
- R5: The threshold word (address 2) holds almost-empty in bits [4:0] and almost-full in bits [20:16]. Almost empty is live while level <= its threshold, and almost full is live while level >= its threshold.
- R6: Flag bits 8..13 (empty, almost empty, full, almost full, underrun, overrun) are sticky. A write of 0 to a bit clears it and a write of 1 keeps it. A bit whose condition is still live sets again on the next cycle.
- R7: core_pop in transmit mode while the buffer is empty sets flag bit 12 (underrun), and core_rdata is then 0.
- R8: core_push in receive mode while the buffer is full sets flag bit 13 (overrun), and the word is dropped. Status bits 12 and 13 mirror the latched underrun and overrun flags.
- R9: Writing control bit 0 as 0 empties the buffer on that edge and leaves both thresholds unchanged. Bit 0 reads back as 1 from the following cycle.
- R10: With control bit 2 = 1, bus writes to address 4 are ignored and bus reads of address 4 return 0 without removing a word.
- R11: irq is high exactly when control bit 15 is 1 and some flag bit 8+i is set together with control mask bit 8+i.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_we | input | 1 | Bus write strobe |
| reg_re | input | 1 | Bus read strobe (pops when it reads address 4) |
| reg_addr | input | 3 | Word address: 0 control, 1 flags, 2 thresholds, 3 status, 4 data |
| reg_wdata | input | 32 | Bus write data |
| reg_rdata | output | 32 | Bus read data for reg_addr |
| core_push | input | 1 | Serial core stores a word (receive mode) |
| core_wdata | input | 32 | Word from the serial core |
| core_pop | input | 1 | Serial core takes a word (transmit mode) |
| core_rdata | output | 32 | Head word to the serial core, 0 when empty |
| irq | output | 1 | Masked and enabled interrupt request |

## Verification
The hardest state to reach is a sticky flag that has to be told apart from its live condition. The bench has to show that a cleared flag stays clear once its condition is gone, that a kept flag survives after its condition is gone, and that a flag whose condition is still live sets again right after a clear. To get there, the stimulus moves the level across programmed thresholds and then clears with chosen write patterns. It also fills the buffer completely from the serial side and pushes once more, which shows that the extra word is dropped and missing from the drained sequence.

// File: rtl/smp_fifo_pkg.sv
package smp_fifo_pkg;

  localparam int N_FLAGS  = 6;
  localparam int FLAG_LSB = 8;

  localparam int F_EMPTY  = 0;
  localparam int F_AEMPTY = 1;
  localparam int F_FULL   = 2;
  localparam int F_AFULL  = 3;
  localparam int F_UNDER  = 4;
  localparam int F_OVER   = 5;

  localparam int C_RUN    = 0;
  localparam int C_TX     = 1;
  localparam int C_DIRECT = 2;
  localparam int C_IRQEN  = 15;

  localparam int TH_AF_LSB = 16;

  typedef enum logic [2:0] {
    A_CTRL  = 3'd0,
    A_FLAGS = 3'd1,
    A_THR   = 3'd2,
    A_STAT  = 3'd3,
    A_DATA  = 3'd4
  } reg_addr_e;

  function automatic int unsigned lvl_step(input int unsigned lvl,
                                           input logic inc, input logic dec);
    return lvl + int'(inc) - int'(dec);
  endfunction

  function automatic logic at_or_below(input int unsigned lvl, input int unsigned th);
    return lvl <= th;
  endfunction

  function automatic logic at_or_above(input int unsigned lvl, input int unsigned th);
    return lvl >= th;
  endfunction

endpackage

// File: rtl/smp_fifo_store.sv
module smp_fifo_store #(
  parameter int DEPTH = 16,
  parameter int WIDTH = 32,
  parameter int LVL_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             push,
  input  logic [WIDTH-1:0] wdata,
  input  logic             pop,
  output logic [WIDTH-1:0] head,
  output logic [LVL_W-1:0] level
);
  import smp_fifo_pkg::*;

  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [WIDTH-1:0] mem [DEPTH];
  logic [PTR_W-1:0] wr_ptr, rd_ptr;

  function automatic logic [PTR_W-1:0] ptr_adv(input logic [PTR_W-1:0] p);
    return (int'(p) == DEPTH - 1) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (push) mem[wr_ptr] <= wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      level  <= '0;
    end else if (clr) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      level  <= '0;
    end else begin
      if (push) wr_ptr <= ptr_adv(wr_ptr);
      if (pop)  rd_ptr <= ptr_adv(rd_ptr);
      level <= LVL_W'(lvl_step(int'(level), push, pop));
    end
  end

  assign head = mem[rd_ptr];

endmodule

// File: rtl/smp_fifo_flags.sv
module smp_fifo_flags (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic [smp_fifo_pkg::N_FLAGS-1:0] set_vec,
  input  logic                            clr_wr,
  input  logic [smp_fifo_pkg::N_FLAGS-1:0] keep_vec,
  input  logic [smp_fifo_pkg::N_FLAGS-1:0] mask,
  input  logic                            irq_en,
  output logic [smp_fifo_pkg::N_FLAGS-1:0] flags,
  output logic                            irq
);
  import smp_fifo_pkg::*;

  for (genvar i = 0; i < N_FLAGS; i++) begin : g_sticky
    logic nxt;
    assign nxt = set_vec[i] | (flags[i] & (~clr_wr | keep_vec[i]));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) flags[i] <= 1'b0;
      else        flags[i] <= nxt;
    end
  end

  assign irq = irq_en & (|(flags & mask));

endmodule

// File: rtl/smp_fifo_regs.sv
module smp_fifo_regs #(
  parameter int LVL_W  = 5,
  parameter int AE_RST = 2,
  parameter int AF_RST = 14
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic                             reg_we,
  input  logic                             reg_re,
  input  logic [2:0]                       reg_addr,
  input  logic [31:0]                      reg_wdata,
  output logic [31:0]                      reg_rdata,
  input  logic [LVL_W-1:0]                 level,
  input  logic [3:0]                       live,
  input  logic [smp_fifo_pkg::N_FLAGS-1:0]  flags,
  input  logic [31:0]                      data_word,
  output logic                             run,
  output logic                             tx_mode,
  output logic                             direct,
  output logic [smp_fifo_pkg::N_FLAGS-1:0]  mask,
  output logic                             irq_en,
  output logic [LVL_W-1:0]                 th_ae,
  output logic [LVL_W-1:0]                 th_af,
  output logic                             soft_clr,
  output logic                             flag_wr,
  output logic                             data_wr,
  output logic                             data_rd
);
  import smp_fifo_pkg::*;

  logic ctrl_wr, thr_wr;

  assign ctrl_wr  = reg_we & (reg_addr == A_CTRL);
  assign thr_wr   = reg_we & (reg_addr == A_THR);
  assign flag_wr  = reg_we & (reg_addr == A_FLAGS);
  assign data_wr  = reg_we & (reg_addr == A_DATA);
  assign data_rd  = reg_re & (reg_addr == A_DATA);
  assign soft_clr = ctrl_wr & ~reg_wdata[C_RUN];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run     <= 1'b1;
      tx_mode <= 1'b0;
      direct  <= 1'b0;
      mask    <= '0;
      irq_en  <= 1'b0;
    end else begin
      run <= ctrl_wr ? reg_wdata[C_RUN] : 1'b1;
      if (ctrl_wr) begin
        tx_mode <= reg_wdata[C_TX];
        direct  <= reg_wdata[C_DIRECT];
        mask    <= reg_wdata[FLAG_LSB +: N_FLAGS];
        irq_en  <= reg_wdata[C_IRQEN];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      th_ae <= LVL_W'(AE_RST);
      th_af <= LVL_W'(AF_RST);
    end else if (thr_wr) begin
      th_ae <= reg_wdata[LVL_W-1:0];
      th_af <= reg_wdata[TH_AF_LSB +: LVL_W];
    end
  end

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      A_CTRL: begin
        reg_rdata[C_RUN]                 = run;
        reg_rdata[C_TX]                  = tx_mode;
        reg_rdata[C_DIRECT]              = direct;
        reg_rdata[FLAG_LSB +: N_FLAGS]   = mask;
        reg_rdata[C_IRQEN]               = irq_en;
      end
      A_FLAGS: reg_rdata[FLAG_LSB +: N_FLAGS] = flags;
      A_THR: begin
        reg_rdata[LVL_W-1:0]             = th_ae;
        reg_rdata[TH_AF_LSB +: LVL_W]    = th_af;
      end
      A_STAT: begin
        reg_rdata[LVL_W-1:0]             = level;
        reg_rdata[FLAG_LSB +: 4]         = live;
        reg_rdata[FLAG_LSB + F_UNDER]    = flags[F_UNDER];
        reg_rdata[FLAG_LSB + F_OVER]     = flags[F_OVER];
      end
      A_DATA:  reg_rdata = data_word;
      default: reg_rdata = '0;
    endcase
  end

endmodule

// File: rtl/smp_fifo_top.sv
module smp_fifo_top #(
  parameter int DEPTH  = 16,
  parameter int AE_RST = 2,
  parameter int AF_RST = DEPTH - 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_we,
  input  logic        reg_re,
  input  logic [2:0]  reg_addr,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata,
  input  logic        core_push,
  input  logic [31:0] core_wdata,
  input  logic        core_pop,
  output logic [31:0] core_rdata,
  output logic        irq
);
  import smp_fifo_pkg::*;

  localparam int WIDTH = 32;
  localparam int LVL_W = $clog2(DEPTH + 1);

  logic [LVL_W-1:0]   level, th_ae, th_af;
  logic [WIDTH-1:0]   head, data_word;
  logic [N_FLAGS-1:0] flags, mask, set_vec;
  logic [3:0]         live;
  logic run, tx_mode, direct, irq_en, soft_clr, flag_wr, data_wr, data_rd;
  logic empty, full, aempty, afull;
  logic push_req, pop_req, push_ok, pop_ok, und_evt, ovr_evt;

  assign empty  = (level == '0);
  assign full   = (int'(level) == DEPTH);
  assign aempty = at_or_below(int'(level), int'(th_ae));
  assign afull  = at_or_above(int'(level), int'(th_af));

  assign push_req = tx_mode ? (data_wr & ~direct) : core_push;
  assign pop_req  = tx_mode ? core_pop : (data_rd & ~direct);
  assign push_ok  = push_req & ~full & ~soft_clr;
  assign pop_ok   = pop_req & ~empty & ~soft_clr;

  assign und_evt = tx_mode & core_pop & empty;
  assign ovr_evt = ~tx_mode & core_push & full;

  always_comb begin
    live             = '0;
    live[F_EMPTY]    = empty;
    live[F_AEMPTY]   = aempty;
    live[F_FULL]     = full;
    live[F_AFULL]    = afull;
    set_vec          = '0;
    set_vec[3:0]     = live;
    set_vec[F_UNDER] = und_evt;
    set_vec[F_OVER]  = ovr_evt;
  end

  assign core_rdata = (tx_mode & ~empty) ? head : '0;
  assign data_word  = (~direct & ~tx_mode & ~empty) ? head : '0;

  smp_fifo_store #(.DEPTH(DEPTH), .WIDTH(WIDTH), .LVL_W(LVL_W)) store_i (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (soft_clr),
    .push  (push_ok),
    .wdata (tx_mode ? reg_wdata : core_wdata),
    .pop   (pop_ok),
    .head  (head),
    .level (level)
  );

  smp_fifo_regs #(.LVL_W(LVL_W), .AE_RST(AE_RST), .AF_RST(AF_RST)) regs_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_we    (reg_we),
    .reg_re    (reg_re),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .reg_rdata (reg_rdata),
    .level     (level),
    .live      (live),
    .flags     (flags),
    .data_word (data_word),
    .run       (run),
    .tx_mode   (tx_mode),
    .direct    (direct),
    .mask      (mask),
    .irq_en    (irq_en),
    .th_ae     (th_ae),
    .th_af     (th_af),
    .soft_clr  (soft_clr),
    .flag_wr   (flag_wr),
    .data_wr   (data_wr),
    .data_rd   (data_rd)
  );

  smp_fifo_flags flags_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .set_vec  (set_vec),
    .clr_wr   (flag_wr),
    .keep_vec (reg_wdata[FLAG_LSB +: N_FLAGS]),
    .mask     (mask),
    .irq_en   (irq_en),
    .flags    (flags),
    .irq      (irq)
  );

endmodule

// File: rtl/smp_fifo_chk.sv
module smp_fifo_chk #(
  parameter int DEPTH = 16,
  parameter int LVL_W = 5
) (
  input logic             clk,
  input logic             rst_n,
  input logic [LVL_W-1:0] level,
  input logic [LVL_W-1:0] th_ae,
  input logic [LVL_W-1:0] th_af,
  input logic             soft_clr,
  input logic             run,
  input logic             tx_mode,
  input logic             direct,
  input logic             data_wr,
  input logic             data_rd,
  input logic             core_push,
  input logic             core_pop,
  input logic             empty,
  input logic             full,
  input logic             flag_und,
  input logic             flag_ovr,
  input logic             irq_en,
  input logic             irq
);

  AST_LEVEL_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    int'(level) <= DEPTH);  // R2

  AST_SOFT_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    soft_clr |=> (level == '0));  // R9

  AST_SOFT_KEEP_THR: assert property (@(posedge clk) disable iff (!rst_n)
    soft_clr |=> ($stable(th_ae) && $stable(th_af)));  // R9

  AST_RUN_RESTORE: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> run);  // R9

  AST_UNDERRUN_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_mode && core_pop && empty) |=> flag_und);  // R7

  AST_OVERRUN_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    (!tx_mode && core_push && full && !data_rd && !soft_clr) |=> ($stable(level) && flag_ovr));  // R8

  AST_DIRECT_BLOCK: assert property (@(posedge clk) disable iff (!rst_n)
    (direct && tx_mode && data_wr && !core_pop && !soft_clr) |=> $stable(level));  // R10

  AST_IRQ_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    !irq_en |-> !irq);  // R11

endmodule

bind smp_fifo_top smp_fifo_chk #(.DEPTH(DEPTH), .LVL_W(LVL_W)) chk_i (
  .clk       (clk),
  .rst_n     (rst_n),
  .level     (level),
  .th_ae     (th_ae),
  .th_af     (th_af),
  .soft_clr  (soft_clr),
  .run       (run),
  .tx_mode   (tx_mode),
  .direct    (direct),
  .data_wr   (data_wr),
  .data_rd   (data_rd),
  .core_push (core_push),
  .core_pop  (core_pop),
  .empty     (empty),
  .full      (full),
  .flag_und  (flags[smp_fifo_pkg::F_UNDER]),
  .flag_ovr  (flags[smp_fifo_pkg::F_OVER]),
  .irq_en    (irq_en),
  .irq       (irq)
);

// File: tb/smp_fifo_top_tb_top.sv
`timescale 1ns/100ps
module smp_fifo_top_tb_top;

  localparam int DEPTH = 16;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_we = 1'b0, reg_re = 1'b0;
  logic [2:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        core_push = 1'b0, core_pop = 1'b0;
  logic [31:0] core_wdata = '0;
  logic [31:0] core_rdata;
  logic        irq;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;
  logic [31:0] sb_q[$];

  always #2.5 clk = ~clk;

  smp_fifo_top #(.DEPTH(DEPTH)) dut_i (
    .clk(clk), .rst_n(rst_n),
    .reg_we(reg_we), .reg_re(reg_re), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .core_push(core_push), .core_wdata(core_wdata),
    .core_pop(core_pop), .core_rdata(core_rdata), .irq(irq)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  task automatic bus_wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic bus_rd(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_re = 1'b1; reg_addr = a;
    #1 d = reg_rdata;
    @(negedge clk);
    reg_re = 1'b0;
  endtask

  // driver: bus push in transmit mode, expected word into the scoreboard
  task automatic drv_bus_push(input logic [31:0] d);
    bus_wr(3'd4, d);
    sb_q.push_back(d);
  endtask

  // driver: core push in receive mode
  task automatic drv_core_push(input logic [31:0] d, input bit expect_keep);
    @(negedge clk);
    core_push = 1'b1; core_wdata = d;
    @(negedge clk);
    core_push = 1'b0;
    if (expect_keep) sb_q.push_back(d);
  endtask

  // monitor: core-side pop compared with the scoreboard
  task automatic mon_core_pop(input string req);
    logic [31:0] got;
    @(negedge clk);
    core_pop = 1'b1;
    #1 got = core_rdata;
    @(negedge clk);
    core_pop = 1'b0;
    if (sb_q.size() == 0) check(req, got, 32'h0);
    else check(req, got, sb_q.pop_front());
  endtask

  // monitor: bus-side pop compared with the scoreboard
  task automatic mon_bus_pop(input string req);
    logic [31:0] got;
    bus_rd(3'd4, got);
    if (sb_q.size() == 0) check(req, got, 32'h0);
    else check(req, got, sb_q.pop_front());
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++;
      n_chk++;
      $display("FAIL watchdog: actual running expected finished");
      summary();
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R1 reset state
    bus_rd(3'd3, v); check("R1 status", v, 32'h0000_0300);
    bus_rd(3'd1, v); check("R1 flags", v, 32'h0000_0300);
    bus_rd(3'd0, v); check("R1 ctrl", v, 32'h0000_0001);
    bus_rd(3'd2, v); check("R1 thresholds", v, 32'h000E_0002);
    check("R1 irq", {31'b0, irq}, 32'h0);

    // R2 transmit ordering
    bus_wr(3'd0, 32'h0000_0003);
    for (int i = 0; i < 5; i++) drv_bus_push(32'hA5A5_0000 + 32'(i * 7));
    bus_rd(3'd3, v); check("R4 level five", v, 32'h0000_0005);
    for (int i = 0; i < 5; i++) mon_core_pop("R2 tx order");

    // R7 underrun
    mon_core_pop("R7 rdata on empty");
    bus_rd(3'd1, v); check("R7 underrun flag", v, 32'h0000_1300);
    bus_rd(3'd3, v); check("R8 status mirrors underrun", v, 32'h0000_1300);

    // R6 clear one bit, then clear all with live conditions re-setting
    bus_wr(3'd1, 32'hFFFF_EFFF);
    bus_rd(3'd1, v); check("R6 clear underrun only", v, 32'h0000_0300);
    bus_wr(3'd1, 32'h0);
    bus_rd(3'd1, v); check("R6 live re-set", v, 32'h0000_0300);

    // R5 thresholds
    bus_wr(3'd2, 32'h0005_0003);
    for (int i = 0; i < 3; i++) drv_bus_push(32'h1000_0000 + 32'(i));
    bus_rd(3'd3, v); check("R5 at almost-empty limit", v, 32'h0000_0203);
    for (int i = 0; i < 2; i++) drv_bus_push(32'h2000_0000 + 32'(i));
    bus_rd(3'd3, v); check("R5 at almost-full limit", v, 32'h0000_0805);
    bus_rd(3'd1, v); check("R5 latched flags", v, 32'h0000_0B00);

    // R6 write-1 keeps a flag whose condition is gone
    bus_wr(3'd1, 32'hFFFF_FEFF);
    bus_rd(3'd1, v); check("R6 keep with ones", v, 32'h0000_0A00);
    bus_wr(3'd1, 32'h0);
    bus_rd(3'd1, v); check("R6 only live re-sets", v, 32'h0000_0800);

    // R11 interrupt gating
    bus_wr(3'd0, 32'h0000_0803);
    check("R11 irq disabled", {31'b0, irq}, 32'h0);
    bus_wr(3'd0, 32'h0000_8803);
    check("R11 irq enabled", {31'b0, irq}, 32'h1);
    bus_wr(3'd0, 32'h0000_8403);
    check("R11 irq other mask", {31'b0, irq}, 32'h0);

    // R9 soft reset
    bus_wr(3'd0, 32'h0000_0002);
    sb_q.delete();
    bus_rd(3'd3, v); check("R9 level cleared", v, 32'h0000_0300);
    bus_rd(3'd2, v); check("R9 thresholds kept", v, 32'h0005_0003);
    bus_rd(3'd0, v); check("R9 run restored", v, 32'h0000_0003);

    // R10 direct ownership blocks the data window
    bus_wr(3'd0, 32'h0000_0007);
    bus_wr(3'd4, 32'hDEAD_BEEF);
    bus_rd(3'd3, v); check("R10 write ignored", v & 32'h1F, 32'h0);
    bus_wr(3'd0, 32'h0000_0005);
    drv_core_push(32'h0BAD_CAFE, 1'b0);
    bus_rd(3'd4, v); check("R10 read blocked", v, 32'h0);
    bus_rd(3'd3, v); check("R10 no pop", v & 32'h1F, 32'h1);
    bus_wr(3'd0, 32'h0000_0000);

    // R3 and R8 receive fill to full, then overrun
    bus_wr(3'd0, 32'h0000_0001);
    bus_wr(3'd1, 32'h0);
    for (int i = 0; i < DEPTH; i++) drv_core_push(32'hC000_0000 + 32'(i * 3), 1'b1);
    drv_core_push(32'hFFFF_FFFF, 1'b0);
    bus_rd(3'd3, v); check("R8 full status", v, 32'h0000_2C10);
    bus_rd(3'd1, v); check("R8 overrun flag", v & 32'h0000_2000, 32'h0000_2000);
    for (int i = 0; i < DEPTH; i++) mon_bus_pop("R3 rx order");
    bus_rd(3'd3, v); check("R3 drained", v & 32'h1F, 32'h0);
    bus_rd(3'd4, v); check("R3 empty read", v, 32'h0);

    done = 1'b1;
    summary();
    $finish;
  end

endmodule